// File: doc/BRIEF.md
# Integer to single-precision converter

This unit turns a signed two's-complement integer, 32 or 64 bits wide, into an IEEE-754 single-precision value. The result goes into the low 32-bit lane of a wide vector destination. The unit is the arithmetic and write-back stage of a scalar conversion operation. It finds the leading one of the magnitude, normalizes the significand, rounds it to 24 bits, and then assembles the full destination vector. The upper part of that vector is built according to which of three operation encodings is in force.

The rounding direction comes from a global two-bit field unless a per-operation override is marked valid. The 64-bit source form applies only when the core runs in 64-bit mode; in any other mode the low 32 bits are converted as a signed value. The inexact flag reports whether any magnitude bit was lost. The result and the flag are registered, so both appear one clock edge after the operands are presented.

Top module: `i2f_lane_unit`

## Requirements
- R1: While the active-low synchronous reset is asserted, the next rising edge clears `dst` to all zeros and `inexact` to 0.
- R2: When `wide_sel` and `long_mode` are not both 1, `src[31:0]` is converted as a signed 32-bit integer. The single-precision encoding (bit 31 sign, bits 30:23 biased exponent with bias 127, bits 22:0 fraction) appears in `dst[31:0]` one rising edge after the operands.
- R3: When `wide_sel` and `long_mode` are both 1, all 64 bits of `src` are converted as a signed integer.
- R4: When `long_mode` is 0, `wide_sel` has no effect: the result equals the 32-bit conversion of `src[31:0]`, whatever `src[63:32]` holds.
- R5: The two-bit rounding field selects the direction as follows: 00 is nearest with ties to even, 01 is toward negative infinity, 10 is toward positive infinity, and 11 is toward zero. `rc_global` is used when `rc_ovr_en` is 0.
- R6: When `rc_ovr_en` is 1, `rc_ovr` sets the rounding direction and `rc_global` is ignored.
- R7: `inexact` is 1 exactly when the rounded result differs from the integer. It is never 1 for a magnitude of at most 2^24. It reports the conversion even when the low lane is masked off.
- R8: A zero source gives +0.0 (0x00000000). The 64-bit source -2^63 gives exactly 0xDF000000 with `inexact` 0.
- R9: When `enc_sel` is 00 (legacy form), `dst[MAX_VL-1:32]` equals `old_dst[MAX_VL-1:32]`.
- R10: When `enc_sel` is 01 (three-operand form), 10 or 11 (masked form), `dst[127:32]` equals `vsrc1[127:32]` and `dst[MAX_VL-1:128]` is zero.
- R11: In the masked form with `mask0` 0, `dst[31:0]` takes `old_dst[31:0]` when `zero_mask` is 0, and is zero when `zero_mask` is 1. `zero_mask` has no effect when `mask0` is 1 or when the encoding is 00 or 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src | input | 64 | Integer source |
| wide_sel | input | 1 | Request for the 64-bit source width |
| long_mode | input | 1 | Core is in 64-bit mode |
| rc_global | input | 2 | Global rounding direction |
| rc_ovr | input | 2 | Per-operation rounding direction |
| rc_ovr_en | input | 1 | Per-operation rounding direction is valid |
| vsrc1 | input | MAX_VL | First vector source |
| old_dst | input | MAX_VL | Current destination contents |
| enc_sel | input | 2 | Encoding form: 00 legacy, 01 three-operand, 1x masked |
| mask0 | input | 1 | Writemask bit for the low lane |
| zero_mask | input | 1 | Zeroing instead of merging for a masked-off lane |
| dst | output | MAX_VL | New destination vector |
| inexact | output | 1 | Rounding discarded a nonzero part |

## Verification
Every result, whether it is the rounded lane, the inexact flag or a merged or zeroed upper part, is due on the first rising edge after the operands are driven. The bench drives operands on a falling edge and samples one time unit after the next rising edge, so each check sees exactly the registered response to one stimulus. The checker's properties use a one-cycle implication for the same reason. The sweep covers all four rounding directions, with and without the override, across boundary integers near 2^24, near the 32-bit limits, at -2^63, and across a pseudo-random set of values.

// File: rtl/i2f_pkg.sv
// Package i2f_pkg: shared encodings for the integer to single-precision unit.
// Assumes a two-bit rounding field and a two-bit encoding-form field.
package i2f_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_ZERO      = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ENC_LEGACY   = 2'b00,
        ENC_THREE_OP = 2'b01,
        ENC_MASKED   = 2'b10,
        ENC_MASKED_B = 2'b11
    } enc_e;

    localparam int unsigned SP_W    = 32;
    localparam int unsigned SP_MANT = 23;
    localparam int unsigned SP_EXP  = 8;
    localparam int unsigned SP_BIAS = 127;

endpackage

// File: rtl/i2f_normalize.sv
// Module i2f_normalize: picks the effective source width, takes the
// magnitude, finds its leading one and left-aligns it at the top bit.
// Assumes SRC_W is 64 and that the narrow form occupies the low 32 bits.
module i2f_normalize #(
    parameter int unsigned SRC_W    = 64,
    parameter int unsigned NARROW_W = 32,
    localparam int unsigned POS_W   = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0] src,
    input  logic             wide_sel,
    input  logic             long_mode,
    output logic             sign,
    output logic             is_zero,
    output logic [POS_W-1:0] msb_pos,
    output logic [SRC_W-1:0] norm
);

    logic [SRC_W-1:0] eff;
    logic [SRC_W-1:0] mag;

    // Sign-extend the narrow form unless the wide form is honoured.
    always_comb begin
        if (wide_sel && long_mode)
            eff = src;
        else
            eff = {{(SRC_W-NARROW_W){src[NARROW_W-1]}}, src[NARROW_W-1:0]};
        sign    = eff[SRC_W-1];
        mag     = sign ? (~eff + 1'b1) : eff;
        is_zero = (mag == '0);
    end

    // Locate the highest set bit of the magnitude.
    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (mag[i]) msb_pos = POS_W'(i);
        end
    end

    // Shift the leading one up to the top bit.
    always_comb begin
        norm = mag << (POS_W'(SRC_W-1) - msb_pos);
    end

endmodule

// File: rtl/i2f_round.sv
// Module i2f_round: rounds a left-aligned magnitude to a 24-bit significand
// and packs the single-precision encoding. Assumes the leading one sits at
// norm[SRC_W-1]. The exponent never overflows for SRC_W up to 128.
module i2f_round
    import i2f_pkg::*;
#(
    parameter int unsigned SRC_W  = 64,
    localparam int unsigned POS_W = $clog2(SRC_W),
    localparam int unsigned G_IDX = SRC_W - 2 - SP_MANT
) (
    input  logic              sign,
    input  logic              is_zero,
    input  logic [POS_W-1:0]  msb_pos,
    input  logic [SRC_W-1:0]  norm,
    input  rmode_e            rmode,
    output logic [SP_W-1:0]   result,
    output logic              inexact
);

    logic [SP_MANT-1:0] frac;
    logic               guard;
    logic               sticky;
    logic               inc;
    logic [SP_MANT:0]   sum;
    logic [SP_EXP-1:0]  exp_v;
    logic               unused_lead;

    assign unused_lead = norm[SRC_W-1];

    // Split the aligned magnitude into kept fraction, guard and sticky.
    always_comb begin
        frac   = norm[SRC_W-2 -: SP_MANT];
        guard  = norm[G_IDX];
        sticky = |norm[G_IDX-1:0];
    end

    // Decide the rounding increment for the selected direction.
    always_comb begin
        unique case (rmode)
            RM_NEAR_EVEN: inc = guard & (sticky | frac[0]);
            RM_DOWN:      inc = sign & (guard | sticky);
            RM_UP:        inc = ~sign & (guard | sticky);
            default:      inc = 1'b0;
        endcase
        inexact = guard | sticky;
    end

    // Apply the increment, absorb a carry into the exponent and pack.
    always_comb begin
        sum   = {1'b0, frac} + {{SP_MANT{1'b0}}, inc};
        exp_v = SP_EXP'(SP_BIAS) + SP_EXP'(msb_pos) + SP_EXP'(sum[SP_MANT]);
        if (is_zero)
            result = '0;
        else
            result = {sign, exp_v, sum[SP_MANT-1:0]};
    end

endmodule

// File: rtl/i2f_lane_merge.sv
// Module i2f_lane_merge: builds the destination vector from the converted
// lane, the old destination and the first vector source, following the
// encoding form and the low-lane writemask. Assumes MAX_VL >= 128.
module i2f_lane_merge
    import i2f_pkg::*;
#(
    parameter int unsigned MAX_VL = 512
) (
    input  logic [SP_W-1:0]   conv,
    input  logic [MAX_VL-1:0] old_dst,
    input  logic [MAX_VL-1:0] vsrc1,
    input  enc_e              enc,
    input  logic              mask0,
    input  logic              zero_mask,
    output logic [MAX_VL-1:0] merged
);

    logic [SP_W-1:0] low_lane;
    logic [127:SP_W] mid_part;

    // Choose the low lane: the result, or the masked-off value.
    always_comb begin
        if ((enc == ENC_MASKED || enc == ENC_MASKED_B) && !mask0)
            low_lane = zero_mask ? '0 : old_dst[SP_W-1:0];
        else
            low_lane = conv;
    end

    // Choose bits 127:32 from the old destination or the first source.
    always_comb begin
        mid_part = (enc == ENC_LEGACY) ? old_dst[127:SP_W] : vsrc1[127:SP_W];
    end

    // Bits above 128 are kept in legacy form and cleared otherwise.
    generate
        if (MAX_VL > 128) begin : g_upper
            logic unused_vsrc_hi;
            assign unused_vsrc_hi = ^vsrc1[MAX_VL-1:128];
            always_comb begin
                merged = {(enc == ENC_LEGACY) ? old_dst[MAX_VL-1:128]
                                              : {(MAX_VL-128){1'b0}},
                          mid_part, low_lane};
            end
        end else begin : g_flat
            always_comb begin
                merged = {mid_part, low_lane};
            end
        end
    endgenerate

endmodule

// File: rtl/i2f_lane_unit.sv
// Module i2f_lane_unit: top of the integer to single-precision converter.
// Picks the rounding direction and registers the merged destination and
// the inexact flag, so results appear one rising edge after the operands.
// Assumes a synchronous active-low reset and MAX_VL >= 128.
module i2f_lane_unit
    import i2f_pkg::*;
#(
    parameter int unsigned MAX_VL = 512,
    parameter int unsigned SRC_W  = 64,
    localparam int unsigned POS_W = $clog2(SRC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src,
    input  logic              wide_sel,
    input  logic              long_mode,
    input  logic [1:0]        rc_global,
    input  logic [1:0]        rc_ovr,
    input  logic              rc_ovr_en,
    input  logic [MAX_VL-1:0] vsrc1,
    input  logic [MAX_VL-1:0] old_dst,
    input  logic [1:0]        enc_sel,
    input  logic              mask0,
    input  logic              zero_mask,
    output logic [MAX_VL-1:0] dst,
    output logic              inexact
);

    rmode_e            rmode;
    logic              n_sign;
    logic              n_zero;
    logic [POS_W-1:0]  n_pos;
    logic [SRC_W-1:0]  n_norm;
    logic [SP_W-1:0]   r_result;
    logic              r_inexact;
    logic [MAX_VL-1:0] merged;

    // The per-operation direction wins over the global one when valid.
    always_comb begin
        rmode = rmode_e'(rc_ovr_en ? rc_ovr : rc_global);
    end

    i2f_normalize #(.SRC_W(SRC_W)) u_norm (
        .src       (src),
        .wide_sel  (wide_sel),
        .long_mode (long_mode),
        .sign      (n_sign),
        .is_zero   (n_zero),
        .msb_pos   (n_pos),
        .norm      (n_norm)
    );

    i2f_round #(.SRC_W(SRC_W)) u_round (
        .sign    (n_sign),
        .is_zero (n_zero),
        .msb_pos (n_pos),
        .norm    (n_norm),
        .rmode   (rmode),
        .result  (r_result),
        .inexact (r_inexact)
    );

    i2f_lane_merge #(.MAX_VL(MAX_VL)) u_merge (
        .conv      (r_result),
        .old_dst   (old_dst),
        .vsrc1     (vsrc1),
        .enc       (enc_e'(enc_sel)),
        .mask0     (mask0),
        .zero_mask (zero_mask),
        .merged    (merged)
    );

    // Register the destination vector and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst     <= '0;
            inexact <= 1'b0;
        end else begin
            dst     <= merged;
            inexact <= r_inexact;
        end
    end

endmodule

// File: rtl/i2f_lane_unit_chk.sv
// Module i2f_lane_unit_chk: port-level properties of the converter,
// bound to every instance of i2f_lane_unit. Each property checks the
// registered response one edge after its operands.
module i2f_lane_unit_chk #(
    parameter int unsigned MAX_VL = 512,
    parameter int unsigned SRC_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  src,
    input logic              wide_sel,
    input logic              long_mode,
    input logic [MAX_VL-1:0] vsrc1,
    input logic [MAX_VL-1:0] old_dst,
    input logic [1:0]        enc_sel,
    input logic              mask0,
    input logic              zero_mask,
    input logic [MAX_VL-1:0] dst,
    input logic              inexact
);

    logic narrow;
    logic src_zero;
    logic small_mag;
    logic masked_off;

    // Operand classifications used by the properties.
    always_comb begin
        narrow     = !(wide_sel && long_mode);
        src_zero   = narrow ? (src[31:0] == '0) : (src == '0);
        small_mag  = narrow && ($signed(src[31:0]) <= 32'sd16777216)
                            && ($signed(src[31:0]) >= -32'sd16777216);
        masked_off = enc_sel[1] && !mask0;
    end

    p_legacy_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_sel == 2'b00) |=> (dst[MAX_VL-1:32] == $past(old_dst[MAX_VL-1:32])));

    p_mid_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_sel != 2'b00) |=> (dst[127:32] == $past(vsrc1[127:32])));

    generate
        if (MAX_VL > 128) begin : g_hi
            p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (enc_sel != 2'b00) |=> (dst[MAX_VL-1:128] == '0));
        end
    endgenerate

    p_mask_merge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_off && !zero_mask) |=> (dst[31:0] == $past(old_dst[31:0])));

    p_mask_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_off && zero_mask) |=> (dst[31:0] == 32'h0));

    p_zero_plus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_zero && !masked_off) |=> (dst[31:0] == 32'h0 && !inexact));

    p_min_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!narrow && src == {1'b1, {(SRC_W-1){1'b0}}} && !masked_off)
        |=> (dst[31:0] == 32'hDF00_0000 && !inexact));

    p_exact_small_r7: assert property (@(posedge clk) disable iff (!rst_n)
        small_mag |=> !inexact);

endmodule

bind i2f_lane_unit i2f_lane_unit_chk #(.MAX_VL(MAX_VL), .SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .wide_sel  (wide_sel),
    .long_mode (long_mode),
    .vsrc1     (vsrc1),
    .old_dst   (old_dst),
    .enc_sel   (enc_sel),
    .mask0     (mask0),
    .zero_mask (zero_mask),
    .dst       (dst),
    .inexact   (inexact)
);

// File: tb/test_i2f_lane_unit.sv
// Bench for i2f_lane_unit: sweeps boundary and pseudo-random integers over
// every rounding direction and source form, then the merge rules. The
// expected values come from quotient and remainder arithmetic.
module test_i2f_lane_unit;

    localparam int unsigned MAX_VL = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [63:0]       src = '0;
    logic              wide_sel = 1'b0;
    logic              long_mode = 1'b0;
    logic [1:0]        rc_global = 2'b00;
    logic [1:0]        rc_ovr = 2'b00;
    logic              rc_ovr_en = 1'b0;
    logic [MAX_VL-1:0] vsrc1 = '0;
    logic [MAX_VL-1:0] old_dst = '0;
    logic [1:0]        enc_sel = 2'b00;
    logic              mask0 = 1'b1;
    logic              zero_mask = 1'b0;
    logic [MAX_VL-1:0] dst;
    logic              inexact;

    int checks = 0;
    int errors = 0;
    logic [63:0] lfsr = 64'hACE1_2468_1357_9BDF;

    localparam logic [63:0] PATS [0:19] = '{
        64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_00FF_FFFF,
        64'h0000_0000_0100_0000, 64'h0000_0000_0100_0001, 64'h0000_0000_0100_0003,
        64'h0000_0000_0100_0002, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000,
        64'hFFFF_FFFF_8000_0001, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
        64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FEFF_FFFF, 64'h1234_5678_9ABC_DEF0,
        64'hFFFF_FFFF_FF00_0001, 64'h0000_0000_0500_0003, 64'hABCD_0000_0000_0000,
        64'h0000_0000_00C0_0001
    };

    always #5 clk = ~clk;

    i2f_lane_unit #(.MAX_VL(MAX_VL)) i_i2f_lane_unit (
        .clk, .rst_n, .src, .wide_sel, .long_mode, .rc_global, .rc_ovr,
        .rc_ovr_en, .vsrc1, .old_dst, .enc_sel, .mask0, .zero_mask,
        .dst, .inexact
    );

    // Reference: {inexact, bits} from quotient and remainder arithmetic.
    function automatic logic [32:0] ref_conv(logic [63:0] v_in, bit wide,
                                             bit lm, logic [1:0] rm);
        logic [63:0] v, m, q, rem, half;
        bit s, up;
        int p, k, e;
        v = (wide && lm) ? v_in : {{32{v_in[31]}}, v_in[31:0]};
        s = v[63];
        m = s ? (64'd0 - v) : v;
        if (m == 0) return 33'd0;
        p = 0;
        for (int i = 0; i < 64; i++) if (m[i]) p = i;
        e = 127 + p;
        if (p <= 23) begin
            q = m << (23 - p);
            return {1'b0, s, e[7:0], q[22:0]};
        end
        k = p - 23;
        q = m >> k;
        rem = m & ((64'd1 << k) - 64'd1);
        half = 64'd1 << (k - 1);
        case (rm)
            2'b00: up = (rem > half) || (rem == half && q[0]);
            2'b01: up = s && (rem != 0);
            2'b10: up = !s && (rem != 0);
            default: up = 1'b0;
        endcase
        q = q + {63'd0, up};
        if (q[24]) begin
            q = q >> 1;
            e = e + 1;
        end
        return {rem != 0, s, e[7:0], q[22:0]};
    endfunction

    task automatic chk(bit ok, string req, logic [MAX_VL-1:0] act,
                       logic [MAX_VL-1:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic next_lfsr();
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    // One conversion in legacy form; checks the lane, the flag and the upper bits.
    task automatic run_conv(logic [63:0] v, bit wide, bit lm, logic [1:0] rm,
                            bit ovr, string tag);
        logic [32:0] exp_v;
        @(negedge clk);
        src = v; wide_sel = wide; long_mode = lm; enc_sel = 2'b00;
        rc_ovr_en = ovr; rc_ovr = rm; rc_global = ovr ? ~rm : rm;
        next_lfsr();
        old_dst = {8{lfsr}};
        exp_v = ref_conv(v, wide, lm, rm);
        @(posedge clk); #1;
        chk(dst[31:0] == exp_v[31:0], {tag, " R5 lane"}, MAX_VL'(dst[31:0]),
            MAX_VL'(exp_v[31:0]));
        chk(inexact == exp_v[32], "R7 inexact", MAX_VL'(inexact), MAX_VL'(exp_v[32]));
        chk(dst[MAX_VL-1:32] == old_dst[MAX_VL-1:32], "R9 legacy upper",
            dst, old_dst);
    endtask

    // One merge case; the lane value is irrelevant when masked off.
    task automatic run_merge(logic [1:0] enc, bit m0, bit zm, string tag);
        logic [MAX_VL-1:0] exp_v;
        logic [32:0] conv;
        @(negedge clk);
        src = 64'h0000_0000_0000_0005; wide_sel = 1'b0; long_mode = 1'b1;
        rc_ovr_en = 1'b0; rc_global = 2'b00;
        enc_sel = enc; mask0 = m0; zero_mask = zm;
        next_lfsr(); old_dst = {8{lfsr}};
        next_lfsr(); vsrc1 = {8{~lfsr}};
        conv = ref_conv(src, 1'b0, 1'b1, 2'b00);
        exp_v = '0;
        exp_v[31:0] = (enc[1] && !m0) ? (zm ? 32'h0 : old_dst[31:0]) : conv[31:0];
        if (enc == 2'b00) exp_v[MAX_VL-1:32] = old_dst[MAX_VL-1:32];
        else exp_v[127:32] = vsrc1[127:32];
        @(posedge clk); #1;
        chk(dst == exp_v, tag, dst, exp_v);
        chk(inexact == 1'b0, "R7 masked flag", MAX_VL'(inexact), '0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        rst_n = 1'b0;
        old_dst = '1;
        vsrc1 = '1;
        src = 64'h7;
        repeat (2) @(posedge clk);
        #1;
        chk(dst == '0 && inexact == 1'b0, "R1 reset", dst, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Boundary sweep over all forms and rounding directions.
        for (int pi = 0; pi < 20; pi++)
            for (int f = 0; f < 4; f++)
                for (int rm = 0; rm < 4; rm++)
                    for (int o = 0; o < 2; o++) begin
                        if (f == 3) tag = "R3 wide";
                        else if (f == 1) tag = "R4 wide ignored";
                        else tag = "R2 narrow";
                        if (o == 1) tag = {tag, " R6 override"};
                        run_conv(PATS[pi], f[0], f[1], rm[1:0], o[0], tag);
                    end

        // Explicit corner values.
        run_conv(64'h0, 1'b1, 1'b1, 2'b10, 1'b0, "R8 zero");
        chk(dst[31:0] == 32'h0, "R8 zero plus", MAX_VL'(dst[31:0]), '0);
        run_conv(64'h8000_0000_0000_0000, 1'b1, 1'b1, 2'b01, 1'b0, "R8 min");
        chk(dst[31:0] == 32'hDF00_0000 && !inexact, "R8 min exact",
            MAX_VL'(dst[31:0]), MAX_VL'(32'hDF00_0000));
        run_conv(64'hFFFF_FFFF_0000_0003, 1'b1, 1'b0, 2'b00, 1'b0, "R4 upper");
        chk(dst[31:0] == 32'h4040_0000, "R4 low three", MAX_VL'(dst[31:0]),
            MAX_VL'(32'h4040_0000));

        // Pseudo-random values in both forms.
        for (int n = 0; n < 300; n++) begin
            next_lfsr();
            run_conv(lfsr >> (n % 48), n[0], 1'b1, n[2:1], n[3],
                     n[0] ? "R3 random" : "R2 random");
        end

        // Merge, zero and writemask rules.
        run_merge(2'b00, 1'b0, 1'b1, "R9 legacy ignores mask");
        run_merge(2'b01, 1'b0, 1'b1, "R10 three-op");
        run_merge(2'b10, 1'b1, 1'b1, "R10 masked written");
        run_merge(2'b10, 1'b0, 1'b0, "R11 merge");
        run_merge(2'b10, 1'b0, 1'b1, "R11 zeroing");
        run_merge(2'b11, 1'b0, 1'b0, "R11 alt merge");
        run_merge(2'b11, 1'b1, 1'b0, "R10 alt written");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule